// File: doc/BRIEF.md
# Dual-Channel Line Driver Fault Latch and Status

This block collects digital fault indications for a two-channel differential line driver and turns them into register state. Each channel reports five conditions: short to supply, short to ground, current limit, excessive offset and open load. Three conditions are shared by both channels: thermal warning, thermal shutdown and supply overvoltage. A condition is captured only while diagnostics are on and its own mask bit is set. Once captured it stays in a sticky fault register until that register is read.

The block also controls the output stages. A short on a channel puts that channel alone into high impedance. Thermal shutdown or overvoltage puts both channels into high impedance. A channel that has been switched off stays off until software writes its retry strobe. A current-limit event is reported but never switches a channel off. An active-low flag output goes low while any fault bit is latched, and a summary register shows the flag, the high-impedance state, the offset faults and a variant ID.

Software reaches the registers through a simple synchronous port. Read data is combinational from the current register state. A read of a fault register clears it on the clock edge that ends the read cycle.

Top module: `linedrv_fault_ctl`

## Requirements
- R1: After reset every register reads 0x00, except the summary register (address 0x05), which reads 0x00 in bits 7:3 and the ID_CODE parameter in bits 2:0. After reset flag_n is 1 and l_hiz and r_hiz are 0.
- R2: The writable registers are address 0x00 (config, all 8 bits), 0x06 (global mask, bits 6:4 only) and 0x07/0x08 (left/right mask, bits 7,6,5,3,2 only). Unused mask bits read 0. Address 0x01 (command) always reads 0. Writes to addresses 0x02–0x05 have no effect.
- R3: A fault bit is captured on the clock edge at which its condition input is 1 only if config bit 7 (diagnostic enable) and the matching mask bit are both 1. Channel condition vectors are {supply, ground, current limit, offset, open} in bits 4:0 and map to channel register bits 7,6,5,3,2. The global inputs thermal warning, thermal shutdown and overvoltage map to bits 6,5,4 of address 0x02.
- R4: A captured bit stays set after its condition goes away. It is cleared on the edge that ends a read cycle of its register (0x02 left/right at 0x03/0x04). If the enabled condition is still present on that edge, the bit stays 1.
- R5: A captured supply or ground short puts only that channel into high impedance. The channel stays there until a write to address 0x01 with bit 6 (left) or bit 7 (right) set.
- R6: A captured thermal shutdown or overvoltage puts both channels into high impedance. Each channel is released only by its own retry bit. A retry on an edge where the cause is captured again leaves the channel off.
- R7: A captured current-limit fault sets its register bit and leaves the channel's high-impedance state unchanged.
- R8: flag_n is 0 exactly while at least one bit of registers 0x02–0x04 is 1. Bit 7 of register 0x05 is the inverse of flag_n.
- R9: In register 0x05, bit 6 is l_hiz, bit 5 is r_hiz, bit 4 is the left offset fault bit, bit 3 is the right offset fault bit, and bits 2:0 are ID_CODE.
- R10: An offset condition is captured only while the effective mute is 1.
- R11: drv_enable equals config bit 6 AND shdn_n. drv_mute equals config bit 5 OR NOT mute_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears a fault register at the end of the cycle |
| reg_rdata | output | 8 | Read data, combinational |
| l_cond | input | 5 | Left conditions {supply, ground, ilim, offset, open} |
| r_cond | input | 5 | Right conditions, same order |
| therm_warn | input | 1 | Thermal warning condition |
| therm_shdn | input | 1 | Thermal shutdown condition |
| over_volt | input | 1 | Supply overvoltage condition |
| shdn_n | input | 1 | Active-low shutdown pin |
| mute_n | input | 1 | Active-low mute pin |
| flag_n | output | 1 | Active-low fault flag |
| l_hiz | output | 1 | Left channel forced to high impedance |
| r_hiz | output | 1 | Right channel forced to high impedance |
| drv_enable | output | 1 | Effective driver enable |
| drv_mute | output | 1 | Effective mute |

## Verification
The bench sweeps every combination of left mask and left condition, and every right condition, and predicts each latched value, each high-impedance state and the flag arithmetically. This exposes a design that ignores a mask bit, swaps a field position, or switches a channel off on current limit. Targeted sequences cover three further cases. A read while the condition is still present must leave the bit set; a design that lets the clear win would drop a live fault. A left-only retry after thermal shutdown must release only the left channel. A retry while overvoltage persists must be refused; a design that lets the retry win would re-enable a channel into the fault. The offset bit is checked with mute off and with mute coming from either the pin or the config bit.

// File: rtl/linedrv_fault_ctl.sv
module linedrv_fault_ctl #(
  parameter logic [2:0] ID_CODE = 3'b100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic [4:0] l_cond,
  input  logic [4:0] r_cond,
  input  logic       therm_warn,
  input  logic       therm_shdn,
  input  logic       over_volt,
  input  logic       shdn_n,
  input  logic       mute_n,
  output logic       flag_n,
  output logic       l_hiz,
  output logic       r_hiz,
  output logic       drv_enable,
  output logic       drv_mute
);
  localparam logic [3:0] A_CFG = 4'h0, A_CMD = 4'h1, A_GF = 4'h2, A_LF = 4'h3,
                         A_RF = 4'h4, A_SUM = 4'h5, A_GM = 4'h6, A_LM = 4'h7, A_RM = 4'h8;
  localparam logic [7:0] CH_BITS = 8'hEC;
  localparam logic [7:0] GL_BITS = 8'h70;

  logic [7:0] cfg, gmask, lmask, rmask, gflt, lflt, rflt;
  logic       lhz_q, rhz_q;

  function automatic logic [7:0] place(input logic [4:0] c, input logic muted);
    place = {c[4], c[3], c[2], 1'b0, c[1] & muted, c[0], 2'b00};
  endfunction

  wire diag     = cfg[7];
  wire eff_mute = cfg[5] | ~mute_n;
  assign drv_enable = cfg[6] & shdn_n;
  assign drv_mute   = eff_mute;

  wire [7:0] l_set = diag ? (place(l_cond, eff_mute) & lmask) : 8'h00;
  wire [7:0] r_set = diag ? (place(r_cond, eff_mute) & rmask) : 8'h00;
  wire [7:0] g_set = diag ? ({1'b0, therm_warn, therm_shdn, over_volt, 4'h0} & gmask) : 8'h00;

  wire wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire both_off = g_set[5] | g_set[4];
  wire l_kill  = l_set[7] | l_set[6] | both_off;
  wire r_kill  = r_set[7] | r_set[6] | both_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; gmask <= '0; lmask <= '0; rmask <= '0;
      gflt <= '0; lflt <= '0; rflt <= '0;
      lhz_q <= 1'b0; rhz_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CFG: cfg   <= reg_wdata;
          A_GM:  gmask <= reg_wdata & GL_BITS;
          A_LM:  lmask <= reg_wdata & CH_BITS;
          A_RM:  rmask <= reg_wdata & CH_BITS;
          default: ;
        endcase
      end
      gflt <= ((reg_rd && reg_addr == A_GF) ? 8'h00 : gflt) | g_set;
      lflt <= ((reg_rd && reg_addr == A_LF) ? 8'h00 : lflt) | l_set;
      rflt <= ((reg_rd && reg_addr == A_RF) ? 8'h00 : rflt) | r_set;
      lhz_q <= l_kill | (lhz_q & ~(wr_cmd & reg_wdata[6]));
      rhz_q <= r_kill | (rhz_q & ~(wr_cmd & reg_wdata[7]));
    end
  end

  wire flag_act = |{gflt, lflt, rflt};
  assign flag_n = ~flag_act;
  assign l_hiz  = lhz_q;
  assign r_hiz  = rhz_q;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = cfg;
      A_GF:    reg_rdata = gflt;
      A_LF:    reg_rdata = lflt;
      A_RF:    reg_rdata = rflt;
      A_SUM:   reg_rdata = {flag_act, lhz_q, rhz_q, lflt[3], rflt[3], ID_CODE};
      A_GM:    reg_rdata = gmask;
      A_LM:    reg_rdata = lmask;
      A_RM:    reg_rdata = rmask;
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_NO_CAPTURE_WITHOUT_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    !diag |=> ((lflt & ~$past(lflt)) == 8'h00)); // R3
  AST_HIZ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lhz_q) |-> $past(diag && (l_cond[4] || l_cond[3] || therm_shdn || over_volt))); // R5
  AST_HIZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lhz_q && !(reg_wr && reg_addr == A_CMD && reg_wdata[6])) |=> lhz_q); // R6
  AST_ILIM_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!lhz_q && l_cond == 5'b00100 && !therm_shdn && !over_volt) |=> !lhz_q); // R7
  AST_FLAG_ON_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (diag && lmask[7] && l_cond[4]) |=> !flag_n); // R8
  AST_OFFSET_ONLY_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lflt[3]) |-> $past(eff_mute)); // R10
endmodule

// File: tb/linedrv_fault_ctl_bench.sv
`timescale 1ns/1ps
module linedrv_fault_ctl_bench;
  localparam logic [2:0] ID = 3'b100;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [4:0] l_cond = 0, r_cond = 0;
  logic therm_warn = 0, therm_shdn = 0, over_volt = 0, shdn_n = 1, mute_n = 1;
  logic flag_n, l_hiz, r_hiz, drv_enable, drv_mute;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  linedrv_fault_ctl #(.ID_CODE(ID)) u_linedrv_fault_ctl (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  function automatic logic [7:0] place(input logic [4:0] c);
    return {c[4], c[3], c[2], 1'b0, c[1], c[0], 2'b00};
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      peek(a[3:0], v);
      chk("R1", v, (a == 5) ? {5'b0, ID} : 8'h00);
    end
    chk("R1", {flag_n, l_hiz, r_hiz}, 8'h04);

    // R2 register access
    wr(4'h7, 8'hFF); peek(4'h7, v); chk("R2", v, 8'hEC);
    wr(4'h8, 8'hFF); peek(4'h8, v); chk("R2", v, 8'hEC);
    wr(4'h6, 8'hFF); peek(4'h6, v); chk("R2", v, 8'h70);
    wr(4'h0, 8'h5A); peek(4'h0, v); chk("R2", v, 8'h5A);
    wr(4'h1, 8'hFF); peek(4'h1, v); chk("R2", v, 8'h00);
    for (int a = 2; a < 6; a++) begin
      wr(a[3:0], 8'hFF); peek(a[3:0], v);
      chk("R2", v, (a == 5) ? {5'b0, ID} : 8'h00);
    end

    // R11 effective enable and mute
    for (int k = 0; k < 16; k++) begin
      wr(4'h0, {1'b0, k[0], k[1], 5'b0});
      shdn_n = k[2]; mute_n = k[3]; #1;
      chk("R11", {6'b0, drv_enable, drv_mute}, {6'b0, k[0] & k[2], k[1] | ~k[3]});
    end
    shdn_n = 1; mute_n = 1;

    // R3 R5 R7 R8 R9: left sweep over mask and condition, muted
    wr(4'h0, 8'hA0);
    for (int m = 0; m < 32; m++) begin
      wr(4'h7, place(m[4:0]));
      for (int c = 0; c < 32; c++) begin
        logic [4:0] hit;
        hit = c[4:0] & m[4:0];
        l_cond = c[4:0]; @(negedge clk); l_cond = 0;
        peek(4'h3, v); chk("R3", v, place(hit));
        chk("R5", {6'b0, l_hiz, r_hiz}, {6'b0, hit[4] | hit[3], 1'b0});
        chk("R8", {7'b0, flag_n}, {7'b0, hit == 0});
        peek(4'h5, v);
        chk("R9", v, {hit != 0, hit[4] | hit[3], 1'b0, hit[1], 1'b0, ID});
        rd(4'h3, v);
        peek(4'h3, v); chk("R4", v, 8'h00);
        wr(4'h1, 8'h40);
        chk("R5", {7'b0, l_hiz}, 8'h00);
      end
    end

    // R3 R5 R7 right sweep, all bits enabled
    wr(4'h8, 8'hEC);
    for (int c = 0; c < 32; c++) begin
      r_cond = c[4:0]; @(negedge clk); r_cond = 0;
      peek(4'h4, v); chk("R3", v, place(c[4:0]));
      chk("R7", {6'b0, l_hiz, r_hiz}, {6'b0, 1'b0, c[4] | c[3]});
      rd(4'h4, v); wr(4'h1, 8'h80);
      chk("R5", {7'b0, r_hiz}, 8'h00);
    end

    // R3 diagnostic off blocks capture
    wr(4'h0, 8'h20);
    l_cond = 5'h1F; r_cond = 5'h1F; therm_warn = 1; therm_shdn = 1; over_volt = 1;
    @(negedge clk);
    l_cond = 0; r_cond = 0; therm_warn = 0; therm_shdn = 0; over_volt = 0;
    peek(4'h3, v); chk("R3", v, 8'h00);
    peek(4'h2, v); chk("R3", v, 8'h00);
    chk("R3", {6'b0, l_hiz, r_hiz}, 8'h00);

    // R10 offset needs effective mute
    wr(4'h0, 8'h80);
    l_cond = 5'b00010; @(negedge clk); l_cond = 0;
    peek(4'h3, v); chk("R10", v, 8'h00);
    mute_n = 0; l_cond = 5'b00010; @(negedge clk); l_cond = 0; mute_n = 1;
    peek(4'h3, v); chk("R10", v, 8'h08);
    rd(4'h3, v);

    // R4 persistence and read while present
    l_cond = 5'b00100; @(negedge clk); l_cond = 0;
    repeat (5) @(negedge clk);
    peek(4'h3, v); chk("R4", v, 8'h20);
    l_cond = 5'b00100; rd(4'h3, v); chk("R4", v, 8'h20);
    peek(4'h3, v); chk("R4", v, 8'h20);
    l_cond = 0; rd(4'h3, v);
    peek(4'h3, v); chk("R4", v, 8'h00);

    // R6 global faults
    therm_warn = 1; @(negedge clk); therm_warn = 0;
    peek(4'h2, v); chk("R3", v, 8'h40);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h00);
    rd(4'h2, v);
    therm_shdn = 1; @(negedge clk); therm_shdn = 0;
    peek(4'h2, v); chk("R3", v, 8'h20);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h03);
    wr(4'h1, 8'h40);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h01);
    wr(4'h1, 8'h80);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h00);
    rd(4'h2, v);
    over_volt = 1; @(negedge clk);
    wr(4'h1, 8'hC0);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h03);
    over_volt = 0;
    peek(4'h2, v); chk("R4", v, 8'h10);
    chk("R8", {7'b0, flag_n}, 8'h00);
    wr(4'h1, 8'hC0);
    chk("R6", {6'b0, l_hiz, r_hiz}, 8'h00);
    rd(4'h2, v);
    chk("R8", {7'b0, flag_n}, 8'h01);
    finish_up();
  end
endmodule